// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is one channel of a bus-master DMA engine for a sector-oriented disk data port. Software builds a table of 8-byte descriptors in memory and starts the engine with a pointer to that table. Each descriptor names a memory region: the region's address comes first, then a word that holds its length and an end-of-table flag. The engine fetches each descriptor in turn and moves the region's data between memory and the device. The device side always moves whole 512-byte sectors, so a region that does not end on a sector boundary leaves bytes in a small carry buffer. Those bytes are used first by the next region.

There are two directions. In device-to-memory, the engine pulls a sector from the device only when the carry buffer is empty and the region still needs data, and it writes every region byte to memory. In memory-to-device, the engine appends region bytes to the buffer and sends a sector each time a full sector has built up. The walk ends at the descriptor flagged as last, with an interrupt flag and a completion pulse. If the device refuses a beat, the walk stops with an error. Memory and device are plain request/acknowledge ports. Arbitration between channels is done outside this block.

Top module: `sgd_dma_walker`

## Requirements
- R1: After reset, `active`, `err` and `irq` are 0, `cur_ptr` is 0, and neither `mem_req` nor `dev_req` is asserted.
- R2: A `start` pulse is accepted only while the walker is not in the middle of a table. An accepted pulse loads `cur_ptr` with `tbl_ptr` with bits 1:0 cleared, sets `active`, clears `err` and `irq`, and latches `dir_d2m`. A `start` pulse that arrives during a walk has no effect. When `cur_ptr` is zero, an active walker issues no memory request.
- R3: Each descriptor is fetched as two 32-bit reads with `mem_wide`=1: first the region address at `cur_ptr`, then the control word at `cur_ptr`+4.
- R4: The region length in bytes is control-word bits 15:0 with bit 0 forced to 0, and a value of 0 means 65536 bytes. Bits 30:16 are ignored. Region data moves as 16-bit beats with `mem_wide`=0, and the address advances by 2 per beat.
- R5: In device-to-memory mode (`dir_d2m`=1), a sector of 256 halfwords is requested from the device only when the carry buffer is empty and the region still needs data. Halfwords left over from a sector are written to memory first in the next region, in order.
- R6: In memory-to-device mode, a sector is sent to the device each time 256 halfwords are buffered. A remainder smaller than a sector is never sent.
- R7: After a descriptor whose control-word bit 31 is 0, `cur_ptr` advances by 8 and the next descriptor is fetched.
- R8: After the region of a descriptor whose bit 31 is 1, `active` clears, `irq` sets, `cur_ptr` becomes 0, and `xfer_done` pulses for exactly one cycle.
- R9: A `dev_nak` on a device beat clears `active` and sets `err` and `irq`. In this case `cur_ptr` keeps the address of the failing descriptor and `xfer_done` does not pulse.
- R10: A request is held with a stable address and direction until it is acknowledged. `mem_req` and `dev_req` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a table walk |
| dir_d2m | input | 1 | 1: device to memory, 0: memory to device |
| tbl_ptr | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_wide | output | 1 | 1: 32-bit descriptor read, 0: 16-bit data beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory beat accepted |
| dev_req | output | 1 | Device beat request |
| dev_wr | output | 1 | 1: send to the device, 0: take from the device |
| dev_wdata | output | 16 | Halfword to the device |
| dev_rdata | input | 16 | Halfword from the device, valid with `dev_ack` |
| dev_ack | input | 1 | Device beat done |
| dev_nak | input | 1 | Device cannot supply or accept the beat |
| active | output | 1 | Walk in progress |
| err | output | 1 | Walk stopped by the device |
| irq | output | 1 | Walk ended, normally or with an error |
| cur_ptr | output | 32 | Current descriptor address |
| xfer_done | output | 1 | One-cycle completion pulse to the device |

## Verification
A wrong carry-buffer count or a mis-decoded length changes how many halfwords cross the device port. The error shows in the sector count at the end of the walk, and a shifted byte shows at the first memory word past the carry. A wrong pointer step sends the next fetch to the wrong address. The resulting region has the wrong data or the wrong length, and this is visible after one region. Faults are checked through `cur_ptr`, which holds the descriptor that failed. Each sweep runs many sectors under periodic memory stalls, so a handshake slip corrupts data within the same beat.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_L,
    ST_XFER,
    ST_DEV_IN,
    ST_DEV_OUT
  } walk_st_e;

  // Region length in halfwords: byte count bits 15:0, bit 0 dropped, zero = 64 KiB.
  function automatic logic [16:0] region_halves(input logic [31:0] ctl);
    logic [15:0] bytes;
    bytes = ctl[15:0] & 16'hFFFE;
    if (bytes == 16'd0) return 17'h08000;
    return {2'b00, bytes[15:1]};
  endfunction

  function automatic logic is_last(input logic [31:0] ctl);
    return ctl[31];
  endfunction

endpackage

// File: rtl/sgd_carry_fifo.sv
module sgd_carry_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign rdata = store[rd_q];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/sgd_walk_ctrl.sv
module sgd_walk_ctrl
  import sgd_pkg::*;
#(
  parameter int SECT_HW = 256,
  localparam int SCW    = $clog2(SECT_HW),
  localparam int CW     = SCW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_d2m,
  input  logic [31:0]   tbl_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [31:0]   mem_addr,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          dev_req,
  output logic          dev_wr,
  input  logic          dev_ack,
  input  logic          dev_nak,
  input  logic [CW-1:0] fifo_cnt,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic          fifo_flush,
  output logic          push_from_dev,
  output logic          active,
  output logic          err,
  output logic          irq,
  output logic [31:0]   cur_ptr,
  output logic          xfer_done
);

  walk_st_e       st_q;
  logic [31:0]    ptr_q, raddr_q;
  logic [16:0]    left_q;
  logic           last_q, d2m_q, act_q, err_q, irq_q, done_q;
  logic [SCW-1:0] sc_q;

  logic buf_empty, buf_full, in_xfer;
  logic ev_region_end, ev_fault, ev_beat_dev, ev_sect_end;

  assign buf_empty = (fifo_cnt == '0);
  assign buf_full  = (fifo_cnt == CW'(SECT_HW));
  assign in_xfer   = (st_q == ST_XFER);

  // Region finished: no halfwords left, and in the outbound direction no full sector pending.
  assign ev_region_end = in_xfer && (left_q == 17'd0) && (d2m_q || !buf_full);
  assign ev_fault      = dev_req && dev_nak;
  assign ev_beat_dev   = dev_req && dev_ack && !dev_nak;
  assign ev_sect_end   = ev_beat_dev && (sc_q == SCW'(SECT_HW - 1));

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_wide = 1'b0;
    mem_addr = raddr_q;
    case (st_q)
      ST_FETCH_A: begin mem_req = 1'b1; mem_wide = 1'b1; mem_addr = ptr_q; end
      ST_FETCH_L: begin mem_req = 1'b1; mem_wide = 1'b1; mem_addr = ptr_q + 32'd4; end
      ST_XFER: begin
        if (d2m_q) begin
          mem_req = (left_q != 17'd0) && !buf_empty;
          mem_we  = 1'b1;
        end else begin
          mem_req = (left_q != 17'd0) && !buf_full;
        end
      end
      default: ;
    endcase
  end

  assign dev_req       = (st_q == ST_DEV_IN) || (st_q == ST_DEV_OUT);
  assign dev_wr        = (st_q == ST_DEV_OUT);
  assign push_from_dev = (st_q == ST_DEV_IN);
  assign fifo_push     = (in_xfer && !d2m_q && mem_req && mem_ack) ||
                         ((st_q == ST_DEV_IN) && ev_beat_dev);
  assign fifo_pop      = (in_xfer && d2m_q && mem_req && mem_ack) ||
                         ((st_q == ST_DEV_OUT) && ev_beat_dev);
  assign fifo_flush    = (st_q == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      raddr_q <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      d2m_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
      sc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            ptr_q <= tbl_ptr & 32'hFFFF_FFFC;
            act_q <= 1'b1;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            d2m_q <= dir_d2m;
          end else if (act_q && ptr_q != 32'd0) begin
            st_q <= ST_FETCH_A;
          end
        end
        ST_FETCH_A: if (mem_ack) begin
          raddr_q <= mem_rdata;
          st_q    <= ST_FETCH_L;
        end
        ST_FETCH_L: if (mem_ack) begin
          left_q <= region_halves(mem_rdata);
          last_q <= is_last(mem_rdata);
          st_q   <= ST_XFER;
        end
        ST_XFER: begin
          if (ev_region_end) begin
            if (last_q) begin
              act_q  <= 1'b0;
              irq_q  <= 1'b1;
              ptr_q  <= '0;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              ptr_q <= ptr_q + 32'd8;
              st_q  <= ST_FETCH_A;
            end
          end else if (d2m_q && buf_empty) begin
            sc_q <= '0;
            st_q <= ST_DEV_IN;
          end else if (!d2m_q && buf_full) begin
            sc_q <= '0;
            st_q <= ST_DEV_OUT;
          end else if (mem_ack) begin
            raddr_q <= raddr_q + 32'd2;
            left_q  <= left_q - 17'd1;
          end
        end
        ST_DEV_IN, ST_DEV_OUT: begin
          if (ev_fault) begin
            act_q <= 1'b0;
            err_q <= 1'b1;
            irq_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (ev_beat_dev) begin
            sc_q <= sc_q + 1'b1;
            if (ev_sect_end) st_q <= ST_XFER;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active    = act_q;
  assign err       = err_q;
  assign irq       = irq_q;
  assign cur_ptr   = ptr_q;
  assign xfer_done = done_q;

endmodule

// File: rtl/sgd_dma_walker.sv
module sgd_dma_walker #(
  parameter int SECT_BYTES = 512,
  localparam int SECT_HW   = SECT_BYTES / 2,
  localparam int CW        = $clog2(SECT_HW) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dir_d2m,
  input  logic [31:0] tbl_ptr,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_wide,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        dev_req,
  output logic        dev_wr,
  output logic [15:0] dev_wdata,
  input  logic [15:0] dev_rdata,
  input  logic        dev_ack,
  input  logic        dev_nak,
  output logic        active,
  output logic        err,
  output logic        irq,
  output logic [31:0] cur_ptr,
  output logic        xfer_done
);

  logic [CW-1:0] fifo_cnt;
  logic          fifo_push, fifo_pop, fifo_flush, push_from_dev;
  logic [15:0]   fifo_head, fifo_in;

  assign fifo_in   = push_from_dev ? dev_rdata : mem_rdata[15:0];
  assign mem_wdata = fifo_head;
  assign dev_wdata = fifo_head;

  sgd_walk_ctrl #(.SECT_HW(SECT_HW)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .dir_d2m       (dir_d2m),
    .tbl_ptr       (tbl_ptr),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_wide      (mem_wide),
    .mem_addr      (mem_addr),
    .mem_rdata     (mem_rdata),
    .mem_ack       (mem_ack),
    .dev_req       (dev_req),
    .dev_wr        (dev_wr),
    .dev_ack       (dev_ack),
    .dev_nak       (dev_nak),
    .fifo_cnt      (fifo_cnt),
    .fifo_push     (fifo_push),
    .fifo_pop      (fifo_pop),
    .fifo_flush    (fifo_flush),
    .push_from_dev (push_from_dev),
    .active        (active),
    .err           (err),
    .irq           (irq),
    .cur_ptr       (cur_ptr),
    .xfer_done     (xfer_done)
  );

  sgd_carry_fifo #(.DEPTH(SECT_HW), .W(16)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (fifo_in),
    .pop   (fifo_pop),
    .rdata (fifo_head),
    .count (fifo_cnt)
  );

endmodule

// File: rtl/sgd_dma_walker_chk.sv
module sgd_dma_walker_chk #(
  parameter int SECT_HW = 256,
  localparam int CW     = $clog2(SECT_HW) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_wide,
  input logic [31:0]   mem_addr,
  input logic          mem_ack,
  input logic          dev_req,
  input logic          dev_wr,
  input logic          dev_ack,
  input logic          dev_nak,
  input logic          active,
  input logic          err,
  input logic          irq,
  input logic [31:0]   cur_ptr,
  input logic          xfer_done,
  input logic [CW-1:0] fifo_cnt
);

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_req));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wide));

  // R10
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack && !dev_nak |=> dev_req && $stable(dev_wr));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !dev_req);

  // R2
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr[1:0] == 2'b00);

  // R3
  fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wide |-> !mem_we);

  // R5
  sector_in_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req) && !dev_wr |-> fifo_cnt == '0);

  // R6
  sector_out_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req) && dev_wr |-> fifo_cnt == CW'(SECT_HW));

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(SECT_HW));

  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> cur_ptr == 32'd0 && !active && irq && !err);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R9
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !active && irq && !xfer_done);

endmodule

bind sgd_dma_walker sgd_dma_walker_chk #(.SECT_HW(SECT_HW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wide  (mem_wide),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .dev_req   (dev_req),
  .dev_wr    (dev_wr),
  .dev_ack   (dev_ack),
  .dev_nak   (dev_nak),
  .active    (active),
  .err       (err),
  .irq       (irq),
  .cur_ptr   (cur_ptr),
  .xfer_done (xfer_done),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/sgd_dma_walker_tb.sv
module sgd_dma_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_d2m = 1'b0;
  logic [31:0] tbl_ptr = '0;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        dev_req, dev_wr;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;
  logic        dev_ack = 1'b0;
  logic        dev_nak = 1'b0;
  logic        active, err, irq, xfer_done;
  logic [31:0] cur_ptr;

  always #5 clk = ~clk;

  sgd_dma_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_d2m(dir_d2m), .tbl_ptr(tbl_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dev_req(dev_req), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_ack(dev_ack), .dev_nak(dev_nak), .active(active), .err(err), .irq(irq),
    .cur_ptr(cur_ptr), .xfer_done(xfer_done)
  );

  localparam int MASK = 8191;
  logic [15:0] hw [8192];

  int cyc = 0;
  int checks = 0, failures = 0;
  int supplied = 0, avail = 0;
  int sunk = 0, cap = 0, sink_base = 0, sink_bad = 0;
  int done_cnt = 0, mem_req_cycles = 0;
  bit finished = 0;

  function automatic logic [15:0] src_val(input int k);
    return 16'hA000 ^ 16'(k * 7);
  endfunction

  // Memory and device responders, driven away from the active edge.
  always @(negedge clk) begin
    int i;
    cyc = cyc + 1;
    mem_ack = 1'b0;
    if (mem_req) mem_req_cycles = mem_req_cycles + 1;
    if (mem_req && (cyc % 4 != 3)) begin
      mem_ack = 1'b1;
      i = int'(mem_addr[13:1]);
      if (mem_wide) mem_rdata = {hw[(i + 1) & MASK], hw[i]};
      else if (mem_we) hw[i] = mem_wdata;
      else mem_rdata = {16'h0000, hw[i]};
    end
    dev_ack = 1'b0;
    dev_nak = 1'b0;
    if (dev_req) begin
      if (dev_wr) begin
        if (sunk < cap) begin
          dev_ack = 1'b1;
          if (dev_wdata !== hw[(sink_base + sunk) & MASK]) sink_bad = sink_bad + 1;
          sunk = sunk + 1;
        end else dev_nak = 1'b1;
      end else begin
        if (supplied < avail) begin
          dev_ack = 1'b1;
          dev_rdata = src_val(supplied);
          supplied = supplied + 1;
        end else dev_nak = 1'b1;
      end
    end
    if (xfer_done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr_counts();
    supplied = 0; sunk = 0; sink_bad = 0; done_cnt = 0; mem_req_cycles = 0;
  endtask

  task automatic put_desc(input int at, input logic [31:0] addr, input logic [31:0] ctl);
    hw[(at >> 1) & MASK]       = addr[15:0];
    hw[((at >> 1) + 1) & MASK] = addr[31:16];
    hw[((at >> 1) + 2) & MASK] = ctl[15:0];
    hw[((at >> 1) + 3) & MASK] = ctl[31:16];
  endtask

  task automatic go(input logic [31:0] p, input bit d2m);
    @(negedge clk);
    start = 1'b1; tbl_ptr = p; dir_d2m = d2m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int g = 0;
    while (active && g < 120000) begin
      @(negedge clk);
      g = g + 1;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (cyc > 195000 && !finished) begin
      finished = 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    for (int k = 0; k < 8192; k++) hw[k] = 16'h5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!active && !err && !irq, "R1 flags", {active, err, irq}, 0);
    chk(cur_ptr == 0 && !mem_req && !dev_req, "R1 ptr/req", cur_ptr, 0);

    // R2 zero pointer: active but silent
    clr_counts();
    go(32'h0, 1'b1);
    repeat (40) @(negedge clk);
    chk(active && mem_req_cycles == 0, "R2 zero pointer idle", mem_req_cycles, 0);

    // R4 R5 R8: one region, 1000 bytes device-to-memory
    clr_counts(); avail = 4096;
    put_desc(32'h100, 32'h1000, 32'h8000_03E8);
    go(32'h100, 1'b1);
    wait_end();
    bad = 0;
    for (int k = 0; k < 500; k++) if (hw[16'h0800 + k] !== src_val(k)) bad++;
    chk(bad == 0, "R5 region data", bad, 0);
    chk(supplied == 512, "R5 two sectors read", supplied, 512);
    chk(hw[16'h0800 + 500] == 16'h5A5A, "R4 region end", hw[16'h0800 + 500], 16'h5A5A);
    chk(!active && irq && !err && cur_ptr == 0, "R8 final state", cur_ptr, 0);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);

    // R4 R5 R7 carry across two regions; R2 start mid-walk ignored
    clr_counts();
    put_desc(32'h200, 32'h2000, 32'h00AB_012D);
    put_desc(32'h208, 32'h2000 + 300, 32'h8000_01F4);
    go(32'h200, 1'b1);
    repeat (30) @(negedge clk);
    go(32'h0, 1'b0);
    wait_end();
    bad = 0;
    for (int k = 0; k < 400; k++) if (hw[16'h1000 + k] !== src_val(k)) bad++;
    chk(bad == 0, "R7 carry data in order", bad, 0);
    chk(supplied == 512, "R5 sectors for 400 halfwords", supplied, 512);
    chk(hw[16'h1000 + 400] == 16'h5A5A, "R4 flags ignored, bit0 dropped", hw[16'h1000 + 400], 16'h5A5A);
    chk(done_cnt == 1 && cur_ptr == 0, "R2 busy start ignored", done_cnt, 1);

    // R6 memory-to-device: 500 halfwords -> one sector only
    clr_counts(); cap = 100000; sink_base = 16'h1800;
    for (int k = 0; k < 600; k++) hw[16'h1800 + k] = 16'(k * 13 + 5);
    put_desc(32'h300, 32'h3000, 32'h0000_0190);
    put_desc(32'h308, 32'h3000 + 400, 32'h8000_0258);
    go(32'h300, 1'b0);
    wait_end();
    chk(sunk == 256, "R6 whole sectors only", sunk, 256);
    chk(sink_bad == 0, "R6 sector data", sink_bad, 0);
    chk(done_cnt == 1 && irq && !err, "R8 m2d done", done_cnt, 1);

    // R4 zero length = 64 KiB
    clr_counts(); sink_base = 16'h2000;
    put_desc(32'h380, 32'h4000, 32'h8000_0000);
    go(32'h380, 1'b0);
    wait_end();
    chk(sunk == 32768, "R4 zero length is 64KiB", sunk, 32768);
    chk(sink_bad == 0, "R4 64KiB data", sink_bad, 0);

    // R9 device shortfall, device-to-memory; R2 misaligned pointer
    clr_counts(); avail = 100;
    put_desc(32'h400, 32'h5000, 32'h8000_0190);
    go(32'h403, 1'b1);
    wait_end();
    chk(err && irq && !active, "R9 d2m fault flags", {err, irq, active}, 3'b110);
    chk(cur_ptr == 32'h400, "R2 R9 pointer kept", cur_ptr, 32'h400);
    chk(done_cnt == 0, "R9 no done pulse", done_cnt, 0);

    // R9 R7 shortfall in second region, memory-to-device
    clr_counts(); cap = 300; sink_base = 16'h2800;
    put_desc(32'h410, 32'h5000, 32'h0000_0258);
    put_desc(32'h418, 32'h5000 + 600, 32'h8000_0258);
    go(32'h410, 1'b0);
    wait_end();
    chk(err && !active && cur_ptr == 32'h418, "R7 R9 second descriptor fault", cur_ptr, 32'h418);
    chk(sunk == 300 && sink_bad == 0, "R9 accepted beats", sunk, 300);

    // R2 start clears flags
    clr_counts();
    go(32'h0, 1'b1);
    repeat (20) @(negedge clk);
    chk(!err && !irq && active && mem_req_cycles == 0, "R2 start clears flags", {err, irq}, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule